// File: doc/BRIEF.md
# Vector Length State Register

This block holds the 32-bit packed state that drives a vector loop sequencer. The state holds a maximum vector length, a current vector length, a sub-vector group size, and three loop offsets: source element, destination element and sub-element destination. Software reaches the state through one write port and one read port. Each port selects a view: the current length, the maximum length, the group size, or the whole packed word. A write can carry either a register operand or a 5-bit immediate.

Every length is held as its value minus one, so a 6-bit field covers lengths 1 to 64. Writes are forced into the legal range. The current length never exceeds the maximum, and the maximum never exceeds the machine word width. A group-size write outside 1..4 is refused and flagged as illegal. The block keeps one saved copy of the whole word for each privilege level. A mode-change pulse exchanges the live word with the copy for the named level, so the same pulse serves both trap entry and trap return.

Top module: `vlen_state_reg`

## Requirements
- R1: After reset the packed word is zero: maximum length 1, current length 1, group size 1, all offsets 0. Every saved copy is also zero.
- R2: Packed layout of `state_word`:
  - bits 5:0 hold the maximum length minus one.
  - bits 11:6 hold the current length minus one.
  - bits 17:12 hold the source offset.
  - bits 23:18 hold the destination offset.
  - bits 25:24 hold the group size minus one.
  - bits 27:26 hold the sub-element offset.
  - bits 31:28 always read zero.
- R3: A current-length write (`wr_sel`=0) stores the request raised to 1 if it is zero and lowered to the present maximum if it is larger. `wr_result` shows that stored length in the same cycle.
- R4: In immediate form (`wr_imm`=1), the length for a current-length, maximum-length or group-size write is `wr_data[4:0]` plus one. All higher data bits are ignored.
- R5: A maximum-length write (`wr_sel`=1) stores the request forced into 1..XLEN. If the new maximum is below the current length, the current length drops to it on the same edge. `wr_result` shows the stored maximum.
- R6: A group-size write (`wr_sel`=2) of 1..4 stores code 0..3 and returns the size on `wr_result`. Any other value:
  - raises `wr_illegal` in that cycle.
  - leaves the whole state unchanged.
  - returns the present size on `wr_result`.
- R7: A packed-word write (`wr_sel`=3) loads every field from the word with three adjustments:
  - the maximum length is forced into 1..XLEN.
  - the current length is then forced to at most the new maximum.
  - the reserved bits are dropped.

  `wr_result` shows the resulting word.
- R8: While `swap_en` is high, the live word loads the saved copy for `swap_lvl`, and that copy loads the old live word. A write in the same cycle is ignored: it does not raise `wr_illegal`, and it leaves `wr_result` at zero.
- R9: `rd_data` is combinational. For `rd_sel` 0, 1 and 2 it gives the current length, maximum length and group size as plain values, zero-extended. For `rd_sel` 3 it gives the packed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Written view: 0 length, 1 maximum, 2 group size, 3 packed word |
| wr_imm | input | 1 | Immediate form: only `wr_data[4:0]` is used |
| wr_data | input | 32 | Write operand |
| rd_sel | input | 2 | Read view, same encoding as `wr_sel` |
| swap_en | input | 1 | Exchange the live word with a saved copy |
| swap_lvl | input | LVL_W | Privilege level whose copy is exchanged |
| rd_data | output | 32 | Selected view of the live state |
| wr_result | output | 32 | Value the current write leaves in its view |
| wr_illegal | output | 1 | Group-size write refused |
| state_word | output | 32 | Live packed word |
| mvl_len | output | 7 | Maximum length, 1..64 |
| vl_len | output | 7 | Current length, 1..64 |
| subvl_len | output | 3 | Group size, 1..4 |
| src_off | output | 6 | Source element offset |
| dst_off | output | 6 | Destination element offset |
| sub_off | output | 2 | Sub-element destination offset |

## Verification
A table of writes runs through a single chain of states. This exposes the clamping paths:
- a zero request.
- a request above the present maximum.
- a maximum set below the current length.
- a maximum above XLEN.

Immediate-form entries with junk in the upper data bits separate the plus-one immediate path from the register path. Group-size values of 0 and 5 are placed between legal ones to show that a refused write changes nothing. Directed sequences then cover the following:
- packed words with out-of-range length codes and set reserved bits.
- swaps across several levels, including swaps that collide with a legal or an illegal write.

// File: rtl/vls_pkg.sv
package vls_pkg;

  // Packed live state; field positions are decoded by the loop sequencer.
  typedef struct packed {
    logic [3:0] rsvd;
    logic [1:0] sub_off;
    logic [1:0] subvl;
    logic [5:0] dst_off;
    logic [5:0] src_off;
    logic [5:0] vl;
    logic [5:0] mvl;
  } vls_word_t;

  typedef enum logic [1:0] {
    VIEW_VL    = 2'd0,
    VIEW_MVL   = 2'd1,
    VIEW_SUBVL = 2'd2,
    VIEW_WORD  = 2'd3
  } vls_view_e;

  // Force a requested length into 1..hi.
  function automatic logic [6:0] fit_len(input logic [31:0] req, input logic [6:0] hi);
    if (req == 32'd0)               fit_len = 7'd1;
    else if (req > {25'd0, hi})     fit_len = hi;
    else                            fit_len = req[6:0];
  endfunction

  function automatic logic [6:0] code_to_len(input logic [5:0] c);
    code_to_len = {1'b0, c} + 7'd1;
  endfunction

  function automatic logic [5:0] len_to_code(input logic [6:0] l);
    logic [6:0] t;
    t = l - 7'd1;
    len_to_code = t[5:0];
  endfunction

endpackage

// File: rtl/vls_update.sv
module vls_update
  import vls_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  vls_word_t   cur,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic        wr_imm,
  input  logic [31:0] wr_data,
  output vls_word_t   nxt,
  output logic [31:0] result,
  output logic        illegal
);
  localparam logic [6:0] XLEN_LEN = 7'(XLEN);

  logic [31:0] req;
  logic [31:0] raw_word;
  logic [6:0]  cur_mvl;
  logic [6:0]  cur_vl;
  logic [6:0]  new_len;
  logic [6:0]  new_vl;
  vls_word_t   w;

  always_comb begin
    req      = wr_imm ? ({27'd0, wr_data[4:0]} + 32'd1) : wr_data;
    raw_word = wr_imm ? {27'd0, wr_data[4:0]} : wr_data;
    cur_mvl  = code_to_len(cur.mvl);
    cur_vl   = code_to_len(cur.vl);
    w        = vls_word_t'(raw_word);
    new_len  = 7'd1;
    new_vl   = 7'd1;
    nxt      = cur;
    result   = '0;
    illegal  = 1'b0;
    if (wr_en) begin
      case (vls_view_e'(wr_sel))
        VIEW_VL: begin
          new_len = fit_len(req, cur_mvl);
          nxt.vl  = len_to_code(new_len);
          result  = {25'd0, new_len};
        end
        VIEW_MVL: begin
          new_len = fit_len(req, XLEN_LEN);
          nxt.mvl = len_to_code(new_len);
          if (cur_vl > new_len) nxt.vl = len_to_code(new_len);
          result  = {25'd0, new_len};
        end
        VIEW_SUBVL: begin
          if (req >= 32'd1 && req <= 32'd4) begin
            nxt.subvl = req[1:0] - 2'd1;
            result    = req;
          end else begin
            illegal = 1'b1;
            result  = {29'd0, {1'b0, cur.subvl} + 3'd1};
          end
        end
        default: begin
          new_len  = fit_len({26'd0, w.mvl} + 32'd1, XLEN_LEN);
          new_vl   = fit_len({26'd0, w.vl} + 32'd1, new_len);
          nxt      = w;
          nxt.rsvd = '0;
          nxt.mvl  = len_to_code(new_len);
          nxt.vl   = len_to_code(new_vl);
          result   = nxt;
        end
      endcase
    end
  end

endmodule

// File: rtl/vls_save_bank.sv
module vls_save_bank
  import vls_pkg::*;
#(
  parameter int NUM_PRIV = 4,
  parameter int LVL_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             swap_en,
  input  logic [LVL_W-1:0] swap_lvl,
  input  vls_word_t        live_in,
  output vls_word_t        saved_out
);
  vls_word_t copies [NUM_PRIV];

  for (genvar g = 0; g < NUM_PRIV; g++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        copies[g] <= '0;
      else if (swap_en && swap_lvl == LVL_W'(g))
        copies[g] <= live_in;
    end
  end

  assign saved_out = copies[swap_lvl];

endmodule

// File: rtl/vlen_state_reg.sv
module vlen_state_reg
  import vls_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NUM_PRIV = 4,
  localparam int LVL_W   = (NUM_PRIV > 1) ? $clog2(NUM_PRIV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic             wr_imm,
  input  logic [31:0]      wr_data,
  input  logic [1:0]       rd_sel,
  input  logic             swap_en,
  input  logic [LVL_W-1:0] swap_lvl,
  output logic [31:0]      rd_data,
  output logic [31:0]      wr_result,
  output logic             wr_illegal,
  output logic [31:0]      state_word,
  output logic [6:0]       mvl_len,
  output logic [6:0]       vl_len,
  output logic [2:0]       subvl_len,
  output logic [5:0]       src_off,
  output logic [5:0]       dst_off,
  output logic [1:0]       sub_off
);
  vls_word_t live;
  vls_word_t upd_word;
  vls_word_t saved_word;
  logic      wr_live;

  assign wr_live = wr_en & ~swap_en;

  vls_update #(.XLEN(XLEN)) u_update (
    .cur     (live),
    .wr_en   (wr_live),
    .wr_sel  (wr_sel),
    .wr_imm  (wr_imm),
    .wr_data (wr_data),
    .nxt     (upd_word),
    .result  (wr_result),
    .illegal (wr_illegal)
  );

  vls_save_bank #(.NUM_PRIV(NUM_PRIV), .LVL_W(LVL_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .swap_en   (swap_en),
    .swap_lvl  (swap_lvl),
    .live_in   (live),
    .saved_out (saved_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       live <= '0;
    else if (swap_en) live <= saved_word;
    else              live <= upd_word;
  end

  assign state_word = live;
  assign mvl_len    = code_to_len(live.mvl);
  assign vl_len     = code_to_len(live.vl);
  assign subvl_len  = {1'b0, live.subvl} + 3'd1;
  assign src_off    = live.src_off;
  assign dst_off    = live.dst_off;
  assign sub_off    = live.sub_off;

  always_comb begin
    case (vls_view_e'(rd_sel))
      VIEW_VL:    rd_data = {25'd0, vl_len};
      VIEW_MVL:   rd_data = {25'd0, mvl_len};
      VIEW_SUBVL: rd_data = {29'd0, subvl_len};
      default:    rd_data = state_word;
    endcase
  end

  // Invariant 1 <= VL <= MVL (R3, R5)
  p_vl_within_mvl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vl_len <= mvl_len);

  p_mvl_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mvl_len <= 7'(XLEN));

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state_word[31:28] == 4'd0);

  p_vl_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !swap_en && wr_sel == 2'd0) |=> vl_len == $past(wr_result[6:0]));

  p_illegal_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_illegal |=> state_word == $past(state_word));

  p_illegal_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_illegal |-> (wr_en && !swap_en && wr_sel == 2'd2));

  p_swap_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    swap_en |=> state_word == $past(saved_word));

endmodule

// File: tb/vlen_state_reg_bench.sv
module vlen_state_reg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  typedef struct packed {
    logic [1:0]  sel;
    logic        imm;
    logic [31:0] data;
    logic [6:0]  res;
    logic [6:0]  mvl;
    logic [6:0]  vl;
    logic [2:0]  sub;
    logic        ill;
  } vec_t;

  // sel, imm, data, expected result, mvl, vl, subvl, illegal
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 32'd5,          7'd1,  7'd1,  7'd1,  3'd1, 1'b0}, // R3 clamp to MVL=1
    '{2'd1, 1'b0, 32'd16,         7'd16, 7'd16, 7'd1,  3'd1, 1'b0}, // R5
    '{2'd0, 1'b0, 32'd10,         7'd10, 7'd16, 7'd10, 3'd1, 1'b0}, // R3
    '{2'd0, 1'b0, 32'd0,          7'd1,  7'd16, 7'd1,  3'd1, 1'b0}, // R3 zero
    '{2'd0, 1'b0, 32'd40,         7'd16, 7'd16, 7'd16, 3'd1, 1'b0}, // R3 above MVL
    '{2'd1, 1'b0, 32'd100,        7'd32, 7'd32, 7'd16, 3'd1, 1'b0}, // R5 above XLEN
    '{2'd0, 1'b1, 32'd31,         7'd32, 7'd32, 7'd32, 3'd1, 1'b0}, // R4
    '{2'd1, 1'b1, 32'd7,          7'd8,  7'd8,  7'd8,  3'd1, 1'b0}, // R5 shrink VL
    '{2'd1, 1'b0, 32'd0,          7'd1,  7'd1,  7'd1,  3'd1, 1'b0}, // R5 zero
    '{2'd1, 1'b1, 32'd31,         7'd32, 7'd32, 7'd1,  3'd1, 1'b0}, // R4
    '{2'd0, 1'b1, 32'd9,          7'd10, 7'd32, 7'd10, 3'd1, 1'b0}, // R4
    '{2'd2, 1'b0, 32'd3,          7'd3,  7'd32, 7'd10, 3'd3, 1'b0}, // R6
    '{2'd2, 1'b0, 32'd5,          7'd3,  7'd32, 7'd10, 3'd3, 1'b1}, // R6 illegal
    '{2'd2, 1'b0, 32'd0,          7'd3,  7'd32, 7'd10, 3'd3, 1'b1}, // R6 illegal
    '{2'd2, 1'b1, 32'd3,          7'd4,  7'd32, 7'd10, 3'd4, 1'b0}, // R4 subvl imm
    '{2'd2, 1'b0, 32'd1,          7'd1,  7'd32, 7'd10, 3'd1, 1'b0}, // R6
    '{2'd0, 1'b1, 32'hFFFF_FFE4,  7'd5,  7'd32, 7'd5,  3'd1, 1'b0}  // R4 upper bits
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic        wr_imm = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic        swap_en = 1'b0;
  logic [1:0]  swap_lvl = '0;
  logic [31:0] rd_data, wr_result, state_word;
  logic        wr_illegal;
  logic [6:0]  mvl_len, vl_len;
  logic [2:0]  subvl_len;
  logic [5:0]  src_off, dst_off;
  logic [1:0]  sub_off;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlen_state_reg u_vlen_state_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_imm(wr_imm),
    .wr_data(wr_data), .rd_sel(rd_sel), .swap_en(swap_en), .swap_lvl(swap_lvl),
    .rd_data(rd_data), .wr_result(wr_result), .wr_illegal(wr_illegal),
    .state_word(state_word), .mvl_len(mvl_len), .vl_len(vl_len),
    .subvl_len(subvl_len), .src_off(src_off), .dst_off(dst_off), .sub_off(sub_off)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic read_view(input logic [1:0] s, output logic [31:0] v);
    rd_sel = s;
    #1 v = rd_data;
  endtask

  logic [31:0] w1_in, w1_exp, w2_in, w2_exp, rv;

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    w1_in  = {4'hF, 2'b10, 2'b01, 6'd9, 6'd7, 6'd50, 6'd40};
    w1_exp = {4'h0, 2'b10, 2'b01, 6'd9, 6'd7, 6'd31, 6'd31};
    w2_in  = {4'h0, 2'b01, 2'b11, 6'd5, 6'd3, 6'd10, 6'd3};
    w2_exp = {4'h0, 2'b01, 2'b11, 6'd5, 6'd3, 6'd3,  6'd3};

    repeat (3) @(negedge clk);
    // R1 reset state
    #1 chk("R1", "word", state_word, 32'd0);
    chk("R1", "vl", {25'd0, vl_len}, 32'd1);
    chk("R1", "mvl", {25'd0, mvl_len}, 32'd1);
    chk("R1", "subvl", {29'd0, subvl_len}, 32'd1);
    rst_n = 1'b1;

    // Table walk: R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      string tg;
      @(negedge clk);
      wr_en = 1'b1; wr_sel = VECS[i].sel; wr_imm = VECS[i].imm; wr_data = VECS[i].data;
      if (VECS[i].imm)            tg = "R4";
      else if (VECS[i].sel == 0)  tg = "R3";
      else if (VECS[i].sel == 1)  tg = "R5";
      else                        tg = "R6";
      #1 chk(tg, "result", wr_result, {25'd0, VECS[i].res});
      chk(tg, "illegal", {31'd0, wr_illegal}, {31'd0, VECS[i].ill});
      @(negedge clk);
      wr_en = 1'b0;
      #1 chk(tg, "mvl", {25'd0, mvl_len}, {25'd0, VECS[i].mvl});
      chk(tg, "vl", {25'd0, vl_len}, {25'd0, VECS[i].vl});
      chk(tg, "subvl", {29'd0, subvl_len}, {29'd0, VECS[i].sub});
    end

    // R9 read views: mvl32 vl5 subvl1
    read_view(2'd0, rv); chk("R9", "view vl", rv, 32'd5);
    read_view(2'd1, rv); chk("R9", "view mvl", rv, 32'd32);
    read_view(2'd2, rv); chk("R9", "view subvl", rv, 32'd1);
    read_view(2'd3, rv); chk("R9", "view word", rv, {20'd0, 6'd4, 6'd31});

    // R7 packed word with out-of-range codes and reserved bits
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd3; wr_imm = 1'b0; wr_data = w1_in;
    #1 chk("R7", "result", wr_result, w1_exp);
    @(negedge clk);
    wr_en = 1'b0;
    #1 chk("R7", "word", state_word, w1_exp);
    chk("R2", "src_off", {26'd0, src_off}, 32'd7);
    chk("R2", "dst_off", {26'd0, dst_off}, 32'd9);
    chk("R2", "sub_off", {30'd0, sub_off}, 32'd2);
    chk("R2", "subvl", {29'd0, subvl_len}, 32'd2);

    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd3; wr_data = w2_in;
    @(negedge clk);
    wr_en = 1'b0;
    #1 chk("R7", "word2", state_word, w2_exp);
    chk("R7", "vl clamp", {25'd0, vl_len}, 32'd4);
    read_view(2'd2, rv); chk("R9", "view subvl", rv, 32'd4);

    // R8 swap with level 1 and back
    @(negedge clk);
    swap_en = 1'b1; swap_lvl = 2'd1;
    @(negedge clk);
    swap_en = 1'b0;
    #1 chk("R8", "swap in", state_word, 32'd0);
    @(negedge clk);
    swap_en = 1'b1; swap_lvl = 2'd1;
    @(negedge clk);
    swap_en = 1'b0;
    #1 chk("R8", "swap back", state_word, w2_exp);

    // R8 swap colliding with a legal write: write ignored
    @(negedge clk);
    swap_en = 1'b1; swap_lvl = 2'd2; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'd2;
    #1 chk("R8", "result during swap", wr_result, 32'd0);
    @(negedge clk);
    swap_en = 1'b0; wr_en = 1'b0;
    #1 chk("R8", "lvl2 load", state_word, 32'd0);
    @(negedge clk);
    swap_en = 1'b1; swap_lvl = 2'd2;
    @(negedge clk);
    swap_en = 1'b0;
    #1 chk("R8", "lvl2 restore", state_word, w2_exp);

    // R8 swap colliding with an illegal group-size write
    @(negedge clk);
    swap_en = 1'b1; swap_lvl = 2'd3; wr_en = 1'b1; wr_sel = 2'd2; wr_data = 32'd9;
    #1 chk("R8", "no illegal during swap", {31'd0, wr_illegal}, 32'd0);
    @(negedge clk);
    swap_en = 1'b0; wr_en = 1'b0;
    #1 chk("R8", "lvl3 load", state_word, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule